// File: doc/BRIEF.md
# Virtual Interrupt End-of-Interrupt Handler

This block keeps the completion state of a virtualized local interrupt controller with 256 vectors. It holds a 256-bit in-service set, the vector that is currently being serviced, and the derived processor priority. A delivery strobe marks a vector as in service. An end-of-interrupt request retires the tracked servicing vector and selects the next-highest vector still in service. It then recomputes the priority and reports what the hypervisor side must do next. There are two outcomes. If the per-vector exit bitmap bit is set, the block raises an exit event that carries the retired vector. Otherwise it asks for pending virtual interrupts to be evaluated locally.

The end-of-interrupt input is a valid/ready channel. A request is taken on a clock edge where `eoi_valid` and `eoi_ready` are both high. `eoi_ready` goes low for one cycle after each acceptance, while the pipelined priority encoder finishes. A request held high during that cycle waits and is taken on the next ready edge, so back-to-back requests are served every second cycle. The issuer must hold `eoi_valid` until it is accepted. The delivery strobe, the task priority and the exit bitmap are plain control inputs.

Top module: `veoi_unit`

## Requirements
- R1: `eoi_ready` is high whenever the block is idle. A request is accepted on an edge where `eoi_valid` and `eoi_ready` are both high. `eoi_ready` is low in the cycle after each acceptance. A request still held high in that cycle is accepted on the following edge.
- R2: On acceptance, the in-service bit whose index equals `svc_vec` is cleared, and `insvc` shows this one cycle later.
- R3: Two cycles after acceptance, `svc_vec` holds the index of the highest remaining in-service bit.
- R4: When no in-service bit remains after a retirement, `svc_vec` becomes 0.
- R5: `ppr` equals `tpr` when `tpr[7:4] >= svc_vec[7:4]`, and otherwise equals `{svc_vec[7:4], 4'h0}`. It is recomputed together with every update of `svc_vec`.
- R6: If `exit_map` at the retired vector's index is 1, `exit_pulse` is raised and `exit_vec` carries the retired vector.
- R7: If that bit is 0, `eval_pulse` is raised and `exit_pulse` stays low.
- R8: `exit_pulse` and `eval_pulse` are one cycle wide and never high together. Exactly one of them is high in the cycle two cycles after each acceptance, and both are low otherwise.
- R9: A `dlv_stb` seen while `eoi_ready` is high and `eoi_valid` is low sets the in-service bit at `dlv_vec`. The same strobe sets `svc_vec` to the larger of its old value and `dlv_vec` and recomputes `ppr` per R5. The results are visible one cycle later.
- R10: A `dlv_stb` seen while `eoi_ready` is low, or while `eoi_valid` is high, has no effect.
- R11: After reset, `insvc`, `svc_vec`, `ppr`, `exit_vec` and both pulses are 0, and `eoi_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eoi_valid | input | 1 | End-of-interrupt request valid |
| eoi_ready | output | 1 | Block can accept an end-of-interrupt request |
| dlv_stb | input | 1 | Mark `dlv_vec` as in service |
| dlv_vec | input | 8 | Vector being marked in service |
| tpr | input | 8 | Task priority |
| exit_map | input | 256 | Per-vector choice: 1 selects exit, 0 selects local evaluation |
| exit_pulse | output | 1 | One-cycle exit event |
| exit_vec | output | 8 | Vector retired by the last exit event |
| eval_pulse | output | 1 | One-cycle pending-interrupt evaluation request |
| svc_vec | output | 8 | Vector currently being serviced |
| ppr | output | 8 | Processor priority |
| insvc | output | 256 | In-service set |

## Verification
An acceptance changes `insvc` after the first edge (R2). The new `svc_vec`, `ppr` and the exit or evaluate pulse all appear after the second edge (R3 to R8), and `eoi_ready` is low in the cycle between. The bench notes the cycle number on the falling edge before the accepting edge and queues an expectation due two cycles later. A monitor samples on every falling edge: on the due cycle it compares the pulse kind, the exit vector, `svc_vec` and `ppr`, and on every other cycle it requires both pulses to be low. Delivery results are checked on the falling edge one cycle after the strobe. Delivery strobes that must be dropped are confirmed through `insvc` once the surrounding request has completed.

// File: rtl/veoi_pkg.sv
package veoi_pkg;
  localparam int VW   = 8;
  localparam int NVEC = 1 << VW;
  localparam int GW   = 32;
  localparam int NGRP = NVEC / GW;
  localparam int GIW  = $clog2(GW);

  typedef logic [VW-1:0] vec_t;

  // Record of a retirement travelling from stage one to stage two
  typedef struct packed {
    logic take_exit;
    vec_t vec;
  } retire_t;
endpackage

// File: rtl/veoi_grp_enc.sv
module veoi_grp_enc #(
  parameter int GRP_W = veoi_pkg::GW,
  localparam int IW = $clog2(GRP_W)
) (
  input  logic [GRP_W-1:0] bits_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  // Highest set bit inside one group; later indices override earlier ones
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < GRP_W; i++) begin
      if (bits_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/veoi_grp_pick.sv
module veoi_grp_pick #(
  parameter int N_GRP = veoi_pkg::NGRP,
  parameter int GRP_W = veoi_pkg::GW,
  parameter int V_W   = veoi_pkg::VW,
  localparam int IW = $clog2(GRP_W)
) (
  input  logic [N_GRP-1:0]    grp_any_i,
  input  logic [N_GRP*IW-1:0] grp_idx_i,
  output logic                any_o,
  output logic [V_W-1:0]      vec_o
);
  // Second encoder stage: highest non-empty group wins, 0 when all empty
  always_comb begin
    any_o = 1'b0;
    vec_o = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (grp_any_i[g]) begin
        any_o = 1'b1;
        vec_o = V_W'(g * GRP_W + int'(grp_idx_i[g*IW +: IW]));
      end
    end
  end
endmodule

// File: rtl/veoi_ppr_calc.sv
module veoi_ppr_calc #(
  parameter int V_W = veoi_pkg::VW,
  localparam int HW = V_W / 2
) (
  input  logic [V_W-1:0] tpr_i,
  input  logic [V_W-1:0] svc_i,
  output logic [V_W-1:0] ppr_o
);
  // Priority class comparison on the upper half of each byte
  always_comb begin
    if (tpr_i[V_W-1 -: HW] >= svc_i[V_W-1 -: HW]) ppr_o = tpr_i;
    else ppr_o = {svc_i[V_W-1 -: HW], {HW{1'b0}}};
  end
endmodule

// File: rtl/veoi_unit.sv
module veoi_unit
  import veoi_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            eoi_valid,
  output logic            eoi_ready,
  input  logic            dlv_stb,
  input  logic [VW-1:0]   dlv_vec,
  input  logic [VW-1:0]   tpr,
  input  logic [NVEC-1:0] exit_map,
  output logic            exit_pulse,
  output logic [VW-1:0]   exit_vec,
  output logic            eval_pulse,
  output logic [VW-1:0]   svc_vec,
  output logic [VW-1:0]   ppr,
  output logic [NVEC-1:0] insvc
);
  logic            busy_q;
  logic [NVEC-1:0] isr_q;
  vec_t            svc_q, ppr_q, xvec_q;
  retire_t         ret_q;
  logic            xp_q, ep_q;

  logic [NGRP-1:0]     gany_c, gany_q;
  logic [NGRP*GIW-1:0] gidx_c, gidx_q;

  logic            accept, dlv_take;
  logic [NVEC-1:0] isr_after;
  logic            pick_any;
  vec_t            pick_vec, dlv_svc, ppr_pick, ppr_dlv;

  assign eoi_ready = !busy_q;
  assign accept    = eoi_valid && !busy_q;
  assign dlv_take  = dlv_stb && !busy_q && !eoi_valid;
  assign isr_after = isr_q & ~(NVEC'(1) << svc_q);
  assign dlv_svc   = (dlv_vec > svc_q) ? dlv_vec : svc_q;

  // Stage one of the encoder: one finder per group over the retired set
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    veoi_grp_enc #(.GRP_W(GW)) u_enc (
      .bits_i (isr_after[g*GW +: GW]),
      .any_o  (gany_c[g]),
      .idx_o  (gidx_c[g*GIW +: GIW])
    );
  end

  // Stage two: group selection from registered group results
  veoi_grp_pick #(.N_GRP(NGRP), .GRP_W(GW), .V_W(VW)) u_pick (
    .grp_any_i (gany_q),
    .grp_idx_i (gidx_q),
    .any_o     (pick_any),
    .vec_o     (pick_vec)
  );

  veoi_ppr_calc #(.V_W(VW)) u_ppr_eoi (
    .tpr_i (tpr),
    .svc_i (pick_vec),
    .ppr_o (ppr_pick)
  );

  veoi_ppr_calc #(.V_W(VW)) u_ppr_dlv (
    .tpr_i (tpr),
    .svc_i (dlv_svc),
    .ppr_o (ppr_dlv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      isr_q  <= '0;
      svc_q  <= '0;
      ppr_q  <= '0;
      xvec_q <= '0;
      ret_q  <= '0;
      xp_q   <= 1'b0;
      ep_q   <= 1'b0;
      gany_q <= '0;
      gidx_q <= '0;
    end else begin
      xp_q <= 1'b0;
      ep_q <= 1'b0;
      if (accept) begin
        busy_q          <= 1'b1;
        isr_q           <= isr_after;
        ret_q.vec       <= svc_q;
        ret_q.take_exit <= exit_map[svc_q];
        gany_q          <= gany_c;
        gidx_q          <= gidx_c;
      end else if (busy_q) begin
        busy_q <= 1'b0;
        svc_q  <= pick_any ? pick_vec : '0;
        ppr_q  <= ppr_pick;
        xp_q   <= ret_q.take_exit;
        ep_q   <= !ret_q.take_exit;
        if (ret_q.take_exit) xvec_q <= ret_q.vec;
      end else if (dlv_take) begin
        isr_q[dlv_vec] <= 1'b1;
        svc_q          <= dlv_svc;
        ppr_q          <= ppr_dlv;
      end
    end
  end

  assign exit_pulse = xp_q;
  assign eval_pulse = ep_q;
  assign exit_vec   = xvec_q;
  assign svc_vec    = svc_q;
  assign ppr        = ppr_q;
  assign insvc      = isr_q;

  // R1: one bubble after every acceptance
  p_ready_drop_r1: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && eoi_ready) |=> !eoi_ready);

  // R2: the serviced bit is gone one cycle after acceptance
  p_retire_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && eoi_ready) |=> !insvc[$past(svc_vec)]);

  // R8: outcome arrives two cycles after acceptance
  p_outcome_due_r8: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && eoi_ready) |-> ##2 (exit_pulse || eval_pulse));

  // R8: the two outcomes never coincide
  p_outcome_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(exit_pulse && eval_pulse));

  // R3/R4: after an outcome the serviced vector is in the set, or 0 if empty
  p_svc_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (exit_pulse || eval_pulse) |-> ((insvc == '0) ? (svc_vec == '0) : insvc[svc_vec]));

  // R10: a delivery strobe during a bubble changes nothing in the set
  p_dlv_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (dlv_stb && !eoi_ready) |=> $stable(insvc));
endmodule

// File: tb/tb_veoi_unit.sv
module tb_veoi_unit;
  logic         clk = 0;
  logic         rst = 1;
  logic         eoi_valid = 0;
  logic         eoi_ready;
  logic         dlv_stb = 0;
  logic [7:0]   dlv_vec = 0;
  logic [7:0]   tpr = 0;
  logic [255:0] exit_map = 0;
  logic         exit_pulse, eval_pulse;
  logic [7:0]   exit_vec, svc_vec, ppr;
  logic [255:0] insvc;

  veoi_unit dut (
    .clk(clk), .rst(rst), .eoi_valid(eoi_valid), .eoi_ready(eoi_ready),
    .dlv_stb(dlv_stb), .dlv_vec(dlv_vec), .tpr(tpr), .exit_map(exit_map),
    .exit_pulse(exit_pulse), .exit_vec(exit_vec), .eval_pulse(eval_pulse),
    .svc_vec(svc_vec), .ppr(ppr), .insvc(insvc)
  );

  always #5 clk = ~clk;

  typedef struct {
    int      due;
    bit      ex;
    int      vec;
    int      svc;
    int      pr;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   mon_on = 0;
  bit   done = 0;

  logic [255:0] m_isr = 0;
  int           m_svc = 0;
  int           m_ppr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int ppr_of(int t, int s);
    return ((t >> 4) >= (s >> 4)) ? t : (s & 8'hF0);
  endfunction

  function automatic int top_bit(logic [255:0] v);
    int r = 0;
    for (int i = 0; i < 256; i++) if (v[i]) r = i;
    return r;
  endfunction

  // Driver half: model a retirement and queue what must appear
  task automatic model_eoi();
    exp_t e;
    e.due = cyc + 2;
    e.vec = m_svc;
    e.ex  = exit_map[m_svc];
    m_isr[m_svc] = 1'b0;
    m_svc = top_bit(m_isr);
    m_ppr = ppr_of(int'(tpr), m_svc);
    e.svc = m_svc;
    e.pr  = m_ppr;
    q.push_back(e);
  endtask

  // mode 0: plain; 1: delivery alongside the request; 2: delivery in the bubble
  task automatic do_eoi(input int n, input int mode, input int dv);
    int got = 0;
    @(negedge clk);
    eoi_valid = 1;
    while (got < n) begin
      while (!eoi_ready) @(negedge clk);
      if (mode == 1 && got == 0) begin dlv_stb = 1; dlv_vec = 8'(dv); end
      model_eoi();
      got++;
      @(negedge clk);
      dlv_stb = 0;
      chk(eoi_ready == 1'b0, "R1 ready low after accept", int'(eoi_ready), 0);
      if (got == n) eoi_valid = 0;
      if (mode == 2 && got == 1) begin
        dlv_stb = 1; dlv_vec = 8'(dv);
        @(negedge clk);
        dlv_stb = 0;
      end else begin
        @(negedge clk);
      end
      chk(insvc == m_isr, "R2 in-service set after retire", top_bit(insvc), top_bit(m_isr));
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic deliver(input int v);
    @(negedge clk);
    chk(eoi_ready == 1'b1, "R9 idle before delivery", int'(eoi_ready), 1);
    dlv_stb = 1; dlv_vec = 8'(v);
    m_isr[v] = 1'b1;
    if (v > m_svc) m_svc = v;
    m_ppr = ppr_of(int'(tpr), m_svc);
    @(negedge clk);
    dlv_stb = 0;
    chk(insvc[v] == 1'b1, "R9 delivered bit set", int'(insvc[v]), 1);
    chk(int'(svc_vec) == m_svc, "R9 svc_vec after delivery", int'(svc_vec), m_svc);
    chk(int'(ppr) == m_ppr, "R5 ppr after delivery", int'(ppr), m_ppr);
  endtask

  // Monitor half: compare on the due cycle, demand quiet pulses otherwise
  always @(negedge clk) begin
    if (mon_on) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(exit_pulse == e.ex, "R6 exit pulse", int'(exit_pulse), int'(e.ex));
        chk(eval_pulse == !e.ex, "R7 eval pulse", int'(eval_pulse), int'(!e.ex));
        if (e.ex) chk(int'(exit_vec) == e.vec, "R6 exit vector", int'(exit_vec), e.vec);
        chk(int'(svc_vec) == e.svc, "R3 R4 new svc_vec", int'(svc_vec), e.svc);
        chk(int'(ppr) == e.pr, "R5 ppr after retire", int'(ppr), e.pr);
      end else begin
        chk(!exit_pulse && !eval_pulse, "R8 pulses idle", int'({exit_pulse, eval_pulse}), 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tpr = 8'h40;
    exit_map[8'h85] = 1'b1;
    exit_map[8'h00] = 1'b1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(insvc == '0, "R11 insvc reset", top_bit(insvc), 0);
    chk(svc_vec == 0 && ppr == 0 && exit_vec == 0, "R11 vectors reset", int'(svc_vec), 0);
    chk(eoi_ready == 1, "R11 ready reset", int'(eoi_ready), 1);
    chk(!exit_pulse && !eval_pulse, "R11 pulses reset", int'({exit_pulse, eval_pulse}), 0);
    mon_on = 1;

    deliver(8'h31);
    deliver(8'h85);
    deliver(8'h22);
    do_eoi(1, 0, 0);              // retire 0x85: exit
    do_eoi(2, 0, 0);              // back-to-back: 0x31 then 0x22, both evaluate
    do_eoi(1, 0, 0);              // empty set: retires 0, exit, svc stays 0
    chk(insvc == '0, "R4 set empty", top_bit(insvc), 0);

    // R10: dropped deliveries
    deliver(8'h50);
    do_eoi(1, 1, 8'h77);
    chk(insvc[8'h77] == 1'b0, "R10 delivery with request dropped", int'(insvc[8'h77]), 0);
    deliver(8'h60);
    do_eoi(1, 2, 8'h99);
    chk(insvc[8'h99] == 1'b0, "R10 delivery in bubble dropped", int'(insvc[8'h99]), 0);

    // Group edges and task priority above all classes
    tpr = 8'hF3;
    deliver(8'h1F);
    deliver(8'h20);
    deliver(8'hFF);
    deliver(8'hE0);
    exit_map[8'hE0] = 1'b1;
    do_eoi(3, 0, 0);              // 0xFF, 0xE0, 0x20
    tpr = 8'h10;
    deliver(8'hA7);
    do_eoi(2, 0, 0);              // 0xA7, 0x1F with low task priority
    chk(q.size() == 0, "R8 all outcomes seen", q.size(), 0);

    mon_on = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule